// File: doc/BRIEF.md
# Concatenable Dual-Channel PWM Generator

This block holds two 8-bit pulse-width channels. Each channel has its own buffered period and duty bytes, a polarity bit, an enable, an alignment bit and a tick-select bit. It advances only on a tick that comes from one of two shared tick inputs. In left-aligned mode a channel counts from zero up to one less than its period. In center-aligned mode it counts up to the period and back down again, so each output period lasts twice as many ticks.

A merge control fuses the pair into one 16-bit channel. Channel 0's bytes become the upper half of the period, duty and counter, and channel 1's bytes become the lower half. The merged channel takes its tick select, polarity, alignment and enable from channel 1 and drives pin 1. Pin 0 is held low while the pair is merged. Software-style strobes write the buffer bytes, clear the counters and read the counter bytes. A read of the upper byte in merged mode freezes the lower byte, so a following lower-byte read is coherent with it.

Top module: `pwm_pair_gen`

## Requirements
- R1: In left-aligned mode (`ch_center`=0) with period P>0, the counter has P positions per period, and the active level appears on the first min(D,P) of them. Polarity 1 makes the active level high. Polarity 0 makes it low, so the pin is high for (1−D/P) of the period. A channel advances only on a cycle where its selected tick is 1: `clk_sel`=0 picks `tick_a` and 1 picks `tick_b`.
- R2: In center-aligned mode (`ch_center`=1) with P>0, one period is 2P ticks, with the counter at 0..P−1 counting up and then P..1 counting down. The pin is active for the first D and the last D positions of the period, which is 2·min(D,P) in all.
- R3: An enabled channel whose active period is 0 keeps its counter at 0 and holds its pin at the polarity bit's value.
- R4: A period or duty write goes to a buffer. The running channel takes the buffered values only at the tick that ends a period, and it copies them every cycle while it is disabled.
- R5: A disabled channel holds its counter at 0 and drives its pin to the inverse of its polarity bit. After reset both pins are therefore high, since the polarity bits are 0.
- R6: With `concat_mode`=1, the 16-bit period and duty are {channel 0 byte, channel 1 byte}. Tick select, polarity, alignment and enable come from channel 1, and the output is on `pwm_out[1]`. `ch_en[0]` has no effect and `pwm_out[0]` is 0.
- R7: `concat_mode` takes the value of `concat_in` one cycle later, but only on cycles where both `ch_en` bits are 0. Otherwise it keeps its value.
- R8: A `cnt_wr[i]` strobe sets channel i's counter to 0 and restarts it in the up direction without loading the buffers. In merged mode, either strobe clears the whole 16-bit counter.
- R9: `rd_en` with `rd_sel`=0 returns the upper counter byte on `rd_data` one cycle later, and `rd_sel`=1 returns the lower byte. In merged mode, an upper-byte read latches the lower byte. The next lower-byte read returns that latched value and then releases the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_a | input | 1 | Tick source A |
| tick_b | input | 1 | Tick source B |
| clk_sel | input | 2 | Per-channel tick select (0 = A, 1 = B) |
| ch_en | input | 2 | Per-channel enable |
| ch_pol | input | 2 | Per-channel polarity (1 = active high) |
| ch_center | input | 2 | Per-channel alignment (1 = center) |
| concat_in | input | 1 | Requested merge setting |
| per_wr | input | 2 | Period buffer write strobe per channel |
| dty_wr | input | 2 | Duty buffer write strobe per channel |
| cnt_wr | input | 2 | Counter clear strobe per channel |
| wdata | input | W | Write data byte |
| rd_en | input | 1 | Counter read strobe |
| rd_sel | input | 1 | 0 = upper (channel 0) byte, 1 = lower (channel 1) byte |
| rd_data | output | W | Registered counter read data |
| concat_mode | output | 1 | Current merge state |
| pwm_out | output | 2 | PWM pins |

## Verification
The most delicate collisions happen on the same cycle. A buffer write can land on the very tick that ends a period, and a counter clear can arrive together with a period-ending tick. The random stimulus issues writes, clears, reads and enable toggles on arbitrary cycles while the ticks also fire on arbitrary cycles, so these overlaps come up often. The bench model uses the buffer contents from before the edge for a load at that edge, and it gives the clear priority over the tick. Each pin is compared on every cycle.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  // Active window test: rising half uses strict compare, falling half
  // includes the duty value so both halves contribute the same count.
  function automatic logic win_active(logic falling, int unsigned cnt,
                                      int unsigned dty);
    return falling ? (cnt <= dty) : (cnt < dty);
  endfunction

  // Pin level from enable, zero-period flag, window and polarity.
  function automatic logic pin_level(logic en, logic per_zero, logic act,
                                     logic pol);
    if (!en)      return !pol;
    if (per_zero) return pol;
    return act ? pol : !pol;
  endfunction

endpackage

// File: rtl/pwm_engine.sv
module pwm_engine #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          clr,
  input  logic          center,
  input  logic          pol,
  input  logic [CW-1:0] per_nxt,
  input  logic [CW-1:0] dty_nxt,
  output logic [CW-1:0] cnt,
  output logic          pin
);
  import pwm_pair_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          falling;
  logic [CW-1:0] per_q, dty_q;
  logic          per_zero, at_top, at_bot, period_end, act;

  assign per_zero   = (per_q == '0);
  assign at_top     = per_zero || (cnt >= per_q - ONE);
  assign at_bot     = (cnt <= ONE);
  assign period_end = per_zero || (!center && at_top) ||
                      (center && falling && at_bot);
  assign act        = win_active(falling, int'(cnt), int'(dty_q));
  assign pin        = pin_level(en, per_zero, act, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      falling <= 1'b0;
      per_q   <= '0;
      dty_q   <= '0;
    end else if (!en) begin
      cnt     <= '0;
      falling <= 1'b0;
      per_q   <= per_nxt;
      dty_q   <= dty_nxt;
    end else if (clr) begin
      cnt     <= '0;
      falling <= 1'b0;
    end else if (tick) begin
      if (period_end) begin
        cnt     <= '0;
        falling <= 1'b0;
        per_q   <= per_nxt;
        dty_q   <= dty_nxt;
      end else if (!center || !falling) begin
        if (center && at_top) begin
          cnt     <= per_q;
          falling <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  a_r5_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  a_r8_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (cnt == '0));
  a_r3_zero_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_zero) |=> (cnt == '0));
  a_r2_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && center) |-> (cnt <= per_q));

endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_a,
  input  logic         tick_b,
  input  logic [1:0]   clk_sel,
  input  logic [1:0]   ch_en,
  input  logic [1:0]   ch_pol,
  input  logic [1:0]   ch_center,
  input  logic         concat_in,
  input  logic [1:0]   per_wr,
  input  logic [1:0]   dty_wr,
  input  logic [1:0]   cnt_wr,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         concat_mode,
  output logic [1:0]   pwm_out
);
  localparam int W2 = 2 * W;

  logic             concat_q;
  logic [1:0][W-1:0] per_buf, dty_buf, cnt8;
  logic [1:0]       pin8, tick_ch;
  logic [W2-1:0]    cnt16;
  logic             pin16;
  logic [W-1:0]     cnt_hi, cnt_lo, lo_hold;
  logic             hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          concat_q <= 1'b0;
    else if (ch_en == '0) concat_q <= concat_in;
  end
  assign concat_mode = concat_q;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign tick_ch[i] = clk_sel[i] ? tick_b : tick_a;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_buf[i] <= '0;
        dty_buf[i] <= '0;
      end else begin
        if (per_wr[i]) per_buf[i] <= wdata;
        if (dty_wr[i]) dty_buf[i] <= wdata;
      end
    end

    pwm_engine #(.CW(W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick_ch[i]),
      .en(ch_en[i] && !concat_q), .clr(cnt_wr[i] && !concat_q),
      .center(ch_center[i]), .pol(ch_pol[i]),
      .per_nxt(per_buf[i]), .dty_nxt(dty_buf[i]),
      .cnt(cnt8[i]), .pin(pin8[i])
    );
  end

  pwm_engine #(.CW(W2)) u_wide (
    .clk(clk), .rst_n(rst_n), .tick(tick_ch[1]),
    .en(ch_en[1] && concat_q), .clr((|cnt_wr) && concat_q),
    .center(ch_center[1]), .pol(ch_pol[1]),
    .per_nxt({per_buf[0], per_buf[1]}), .dty_nxt({dty_buf[0], dty_buf[1]}),
    .cnt(cnt16), .pin(pin16)
  );

  assign pwm_out[0] = concat_q ? 1'b0 : pin8[0];
  assign pwm_out[1] = concat_q ? pin16 : pin8[1];

  assign cnt_hi = concat_q ? cnt16[W2-1:W] : cnt8[0];
  assign cnt_lo = concat_q ? cnt16[W-1:0]  : cnt8[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      lo_hold    <= '0;
      hold_valid <= 1'b0;
    end else if (rd_en) begin
      if (!rd_sel) begin
        rd_data <= cnt_hi;
        if (concat_q) begin
          lo_hold    <= cnt_lo;
          hold_valid <= 1'b1;
        end
      end else begin
        rd_data    <= (concat_q && hold_valid) ? lo_hold : cnt_lo;
        hold_valid <= 1'b0;
      end
    end
  end

  a_r7_concat_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en != '0) |=> $stable(concat_q));
  a_r6_even_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    concat_q |=> (cnt8[0] == '0));
  a_r6_even_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(concat_q) && concat_q |-> !pwm_out[0]);

endmodule

// File: tb/tb_pwm_pair_gen.sv
module tb_pwm_pair_gen;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick_a, tick_b, concat_in, rd_en, rd_sel;
  logic [1:0] clk_sel, ch_en, ch_pol, ch_center, per_wr, dty_wr, cnt_wr;
  logic [W-1:0] wdata, rd_data;
  logic concat_mode;
  logic [1:0] pwm_out;

  pwm_pair_gen #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clk_sel(clk_sel), .ch_en(ch_en), .ch_pol(ch_pol), .ch_center(ch_center),
    .concat_in(concat_in), .per_wr(per_wr), .dty_wr(dty_wr), .cnt_wr(cnt_wr),
    .wdata(wdata), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .concat_mode(concat_mode), .pwm_out(pwm_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model: index 0/1 = 8-bit channels, 2 = merged channel.
  int m_pos[3], m_per[3], m_dty[3];
  logic mq;
  logic [1:0][7:0] pb, db;
  logic [7:0] m_lat, exp_rd;
  logic m_lv, rd_chk;
  int evt_age;
  string evt_tag;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int m_cnt(int k, logic ctr);
    if (ctr && m_pos[k] >= m_per[k]) return 2 * m_per[k] - m_pos[k];
    return m_pos[k];
  endfunction

  function automatic logic m_pin(int k, logic en, logic ctr, logic pol);
    logic act;
    if (!en) return !pol;
    if (m_per[k] == 0) return pol;
    if (!ctr) act = m_pos[k] < m_dty[k];
    else act = (m_pos[k] < m_dty[k]) || (m_pos[k] >= 2 * m_per[k] - m_dty[k]);
    return act ? pol : !pol;
  endfunction

  function automatic int idx(int k);
    return (k == 0) ? 0 : 1;
  endfunction

  task automatic model_edge();
    int bp[3], bd[3];
    logic en[3], tk[3], cl[3];
    int hi, lo;
    bp[0] = pb[0]; bp[1] = pb[1]; bp[2] = {pb[0], pb[1]};
    bd[0] = db[0]; bd[1] = db[1]; bd[2] = {db[0], db[1]};
    en[0] = ch_en[0] && !mq; en[1] = ch_en[1] && !mq; en[2] = ch_en[1] && mq;
    cl[0] = cnt_wr[0] && !mq; cl[1] = cnt_wr[1] && !mq; cl[2] = (|cnt_wr) && mq;
    for (int k = 0; k < 3; k++) tk[k] = clk_sel[idx(k)] ? tick_b : tick_a;
    // R9 read path uses counter values before the edge
    if (mq) begin
      hi = m_cnt(2, ch_center[1]) >> 8; lo = m_cnt(2, ch_center[1]) & 255;
    end else begin
      hi = m_cnt(0, ch_center[0]); lo = m_cnt(1, ch_center[1]);
    end
    rd_chk = rd_en;
    if (rd_en) begin
      if (!rd_sel) begin
        exp_rd = 8'(hi);
        if (mq) begin m_lat = 8'(lo); m_lv = 1'b1; end
      end else begin
        exp_rd = (mq && m_lv) ? m_lat : 8'(lo);
        m_lv = 1'b0;
      end
    end
    for (int k = 0; k < 3; k++) begin
      int len;
      len = ch_center[idx(k)] ? 2 * m_per[k] : m_per[k];
      if (!en[k]) begin
        m_pos[k] = 0; m_per[k] = bp[k]; m_dty[k] = bd[k];
      end else if (cl[k]) begin
        m_pos[k] = 0;
      end else if (tk[k]) begin
        if (m_per[k] == 0 || m_pos[k] + 1 == len) begin
          m_pos[k] = 0; m_per[k] = bp[k]; m_dty[k] = bd[k];
        end else m_pos[k] = m_pos[k] + 1;
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (per_wr[i]) pb[i] = wdata;
      if (dty_wr[i]) db[i] = wdata;
    end
    if (ch_en == 2'b00) mq = concat_in;
  endtask

  function automatic string base_tag(int k);
    if (mq) return "R6";
    if (!ch_en[k]) return "R5";
    if (m_per[k] == 0) return "R3";
    return ch_center[k] ? "R2" : "R1";
  endfunction

  task automatic step();
    logic e0, e1;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (mq) begin
      e0 = 1'b0;
      e1 = m_pin(2, ch_en[1], ch_center[1], ch_pol[1]);
    end else begin
      e0 = m_pin(0, ch_en[0], ch_center[0], ch_pol[0]);
      e1 = m_pin(1, ch_en[1], ch_center[1], ch_pol[1]);
    end
    check(evt_age > 0 ? evt_tag : base_tag(0), "pwm_out[0]", int'(pwm_out[0]), int'(e0));
    check(evt_age > 0 ? evt_tag : base_tag(1), "pwm_out[1]", int'(pwm_out[1]), int'(e1));
    check("R7", "concat_mode", int'(concat_mode), int'(mq));
    if (rd_chk) check("R9", "rd_data", int'(rd_data), int'(exp_rd));
    if (evt_age > 0) evt_age--;
  endtask

  task automatic clear_pulses();
    per_wr = '0; dty_wr = '0; cnt_wr = '0; rd_en = 1'b0;
  endtask

  task automatic write_byte(bit is_dty, int ch, logic [7:0] v);
    wdata = v;
    if (is_dty) dty_wr[ch] = 1'b1; else per_wr[ch] = 1'b1;
    step();
    clear_pulses();
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tick_a = 0; tick_b = 0; concat_in = 0; rd_en = 0; rd_sel = 0;
    clk_sel = 0; ch_en = 0; ch_pol = 0; ch_center = 0;
    per_wr = 0; dty_wr = 0; cnt_wr = 0; wdata = 0;
    for (int k = 0; k < 3; k++) begin m_pos[k] = 0; m_per[k] = 0; m_dty[k] = 0; end
    mq = 0; pb = '0; db = '0; m_lat = 0; m_lv = 0; exp_rd = 0; rd_chk = 0;
    evt_age = 0; evt_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R5", "pwm_out after reset", int'(pwm_out), 3);
    check("R7", "concat_mode after reset", int'(concat_mode), 0);
    check("R9", "rd_data after reset", int'(rd_data), 0);

    for (int seg = 0; seg < 40; seg++) begin
      int pv[2], dv[2];
      ch_en = 2'b00;
      step(); step();
      ch_pol = 2'($urandom); ch_center = 2'($urandom); clk_sel = 2'($urandom);
      concat_in = ($urandom % 3) == 0;
      for (int i = 0; i < 2; i++) begin
        pv[i] = $urandom % 13; dv[i] = $urandom % (pv[i] + 2);
      end
      if (concat_in) begin
        pv[0] = ($urandom % 4 == 0) ? 1 : 0; dv[0] = pv[0] & int'($urandom % 2);
      end
      // directed corners
      if (seg == 0) begin // R2: center, P=4 D=1 polarity 0 gives 75% high
        concat_in = 0; ch_center = 2'b11; ch_pol = 2'b00; pv = '{4, 4}; dv = '{1, 1};
      end
      if (seg == 1) begin // R3: zero period, both polarities
        concat_in = 0; ch_pol = 2'b10; pv = '{0, 0}; dv = '{3, 0};
      end
      if (seg == 2) begin // R1: duty above period, left aligned
        concat_in = 0; ch_center = 2'b00; pv = '{5, 3}; dv = '{9, 3};
      end
      if (seg == 3) begin // R6: merged 16-bit, period 0x0103
        concat_in = 1; pv = '{1, 3}; dv = '{0, 200};
      end
      for (int i = 0; i < 2; i++) begin
        write_byte(0, i, 8'(pv[i]));
        write_byte(1, i, 8'(dv[i]));
      end
      step();
      ch_en = (concat_in || seg < 4) ? 2'b11 : 2'(1 + $urandom % 3);
      for (int n = 0; n < 350; n++) begin
        int r;
        r = $urandom % 100;
        tick_a = $urandom % 2;
        tick_b = ($urandom % 3) == 0;
        if (seg >= 4 || n > 150) begin
          if (r < 3) begin
            wdata = 8'($urandom % 12); per_wr[$urandom % 2] = 1'b1;
            evt_tag = "R4"; evt_age = 30;
          end else if (r < 5) begin
            wdata = 8'($urandom % 12); dty_wr[$urandom % 2] = 1'b1;
            evt_tag = "R4"; evt_age = 30;
          end else if (r < 7) begin
            cnt_wr[$urandom % 2] = 1'b1;
            evt_tag = "R8"; evt_age = 3;
          end else if (r < 9) begin
            concat_in = !concat_in; // R7: ignored while any enable is set
          end else if (r < 11) begin
            ch_en[0] = !ch_en[0]; // R6: no effect when merged
          end else if (r < 12) begin
            ch_en[1] = !ch_en[1]; // R5
          end
        end
        if (r >= 20 && r < 32) begin
          rd_en = 1'b1; rd_sel = $urandom % 2;
        end
        step();
        clear_pulses();
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule